// File: doc/BRIEF.md
# Rename Flow Controller

This block governs how decoded instructions move through the register-rename stage of an out-of-order core. Each cycle it may receive a group of up to `WIDTH` instructions, each with a valid bit, a payload and a barrier (serializing) flag. It sends on as many of them as the three downstream structures can take: the reorder buffer, the issue queue and the load/store queue. The payload is carried through unchanged. Mapping registers is not part of this block.

Instructions that cannot be sent are parked in a skid buffer. Decode is told to hold while anything is parked. Parked instructions always leave before newer ones. A barrier instruction waits at the head of the stream until the reorder buffer reports empty and nothing is in flight toward it. It then goes out alone, in slot 0. A squash discards everything parked and walks the controller through two flush states before it resumes.

Top module: `rename_flow_ctl`

## Requirements
- R1: Asynchronous reset, active low, sets `stage_status` to 1 (idle), `out_valid` to 0 and `hold_decode` to 0, and empties the skid buffer.
- R2: With the skid buffer empty and enough credits, the valid input instructions appear one cycle later on output slots 0 upward, in slot order, with invalid input slots squeezed out. `stage_status` becomes 0 (running).
- R3: The number of instructions issued in one cycle is at most the smallest of `WIDTH`, `rob_free`, `iq_free` and `lsq_free`.
- R4: Instructions that are not issued stay in the skid buffer in order. If the previous status was not a stall status, `stage_status` becomes 4 (blocked). If nothing could be issued, it also becomes 4. `hold_decode` is 1 in the same cycle.
- R5: Skid buffer contents are issued before any instruction arriving in the same cycle.
- R6: If some instructions are issued while in a stall status and some are still left, the status becomes 5 (unblocking). It returns to 0 (running) and drops `hold_decode` only once the skid buffer is empty.
- R7: A barrier (`in_barrier` set) issues only as output slot 0, only when `rob_empty` is 1 and `inflight` is 0, and nothing else issues with it. Instructions ahead of it still issue. While it waits at the head, the status is 6 (serialize stall).
- R8: When `squash` is high at a clock edge, the controller issues nothing and empties the skid buffer. Its status then goes 2 (squash start), 3 (squashing), then 0. Input groups that arrive during those cycles are dropped. `hold_decode` is 1 only in the squash-start cycle.
- R9: With the skid buffer empty and no valid input, the status becomes 1 (idle) and nothing issues.
- R10: The skid buffer never exceeds `SKID_DEPTH` entries, provided decode sends at most one further group after it first sees `hold_decode`.
- R11: `out_valid` is always a contiguous run of ones starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| squash | input | 1 | Flush all held and arriving instructions |
| in_valid | input | WIDTH | Per-slot valid bits of the incoming group |
| in_barrier | input | WIDTH | Per-slot serializing flag |
| in_data | input | WIDTH*DATA_W | Per-slot payload, slot j at bits [j*DATA_W +: DATA_W] |
| rob_free | input | CNT_W | Free reorder-buffer entries |
| iq_free | input | CNT_W | Free issue-queue entries |
| lsq_free | input | CNT_W | Free load/store-queue entries |
| rob_empty | input | 1 | Reorder buffer holds no instruction |
| inflight | input | CNT_W | Instructions on their way to the reorder buffer |
| out_valid | output | WIDTH | Per-slot valid bits of the issued group |
| out_data | output | WIDTH*DATA_W | Issued payloads, same layout as `in_data` |
| hold_decode | output | 1 | Tells decode to stop sending |
| stage_status | output | 3 | Controller status, encoded as in the requirements |

## Verification
The bench targets these corner cases:
- A group with gaps in its valid bits. A design that forgets to compact such a group would leave holes in `out_valid`.
- A stall caused by each of the three credit counts in turn. A design that ignores one of them would over-issue.
- A new group arriving while older instructions are still parked. Getting this wrong reorders the stream.
- A barrier that sits behind ordinary instructions. It must wait first on a non-zero in-flight count, then issue once the pipe is drained. A design that checks only `rob_empty` would let it go early. One that issues it alongside other instructions would break serialization.
- A squash while the skid buffer is full, followed by an idle cycle. Stale payloads resurfacing in that idle cycle would show the buffer was never cleared.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQ_START = 3'd2,
    ST_SQ_BUSY  = 3'd3,
    ST_BLOCK    = 3'd4,
    ST_UNBLOCK  = 3'd5,
    ST_SERIAL   = 3'd6
  } rn_status_e;

  function automatic logic is_stall(rn_status_e s);
    return (s == ST_BLOCK) || (s == ST_UNBLOCK) || (s == ST_SERIAL);
  endfunction

endpackage

// File: rtl/rn_budget.sv
module rn_budget #(
  parameter  int WIDTH = 4,
  parameter  int CNT_W = 6,
  localparam int BW    = $clog2(WIDTH + 1)
) (
  input  logic [CNT_W-1:0] rob_free,
  input  logic [CNT_W-1:0] iq_free,
  input  logic [CNT_W-1:0] lsq_free,
  output logic [BW-1:0]    budget
);

  logic [CNT_W-1:0] least;

  always_comb begin
    least = rob_free;
    if (iq_free < least)  least = iq_free;
    if (lsq_free < least) least = lsq_free;
    if (least >= CNT_W'(WIDTH)) budget = BW'(WIDTH);
    else                        budget = BW'(least);
  end

endmodule

// File: rtl/rn_skid.sv
module rn_skid #(
  parameter  int DEPTH = 8,
  parameter  int EW    = 9,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr_en,
  input  logic [CW-1:0]             wr_cnt,
  input  logic [DEPTH-1:0][EW-1:0]  wr_ent,
  output logic [DEPTH-1:0][EW-1:0]  ent,
  output logic [CW-1:0]             cnt
);

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)        cnt_d = '0;
    else if (wr_en) cnt_d = wr_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // payload storage: no reset, loaded only under its enable
  always_ff @(posedge clk) begin
    if (wr_en && !clr) ent <= wr_ent;
  end

endmodule

// File: rtl/rn_select.sv
module rn_select #(
  parameter  int WIDTH  = 4,
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 8,
  localparam int EW     = DATA_W + 1,
  localparam int TOT    = DEPTH + WIDTH,
  localparam int PW     = $clog2(TOT + 1),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int BW     = $clog2(WIDTH + 1)
) (
  input  logic [DEPTH-1:0][EW-1:0]     skid_ent,
  input  logic [CW-1:0]                skid_cnt,
  input  logic [WIDTH-1:0]             in_valid,
  input  logic [WIDTH-1:0][EW-1:0]     in_ent,
  input  logic                         accept,
  input  logic [BW-1:0]                budget,
  input  logic                         drained,
  output logic [WIDTH-1:0]             issue_mask,
  output logic [WIDTH-1:0][DATA_W-1:0] issue_data,
  output logic                         first_is_barrier,
  output logic [DEPTH-1:0][EW-1:0]     left_ent,
  output logic [PW-1:0]                left_n,
  output logic [PW-1:0]                total,
  output logic                         head_barrier
);

  logic [TOT-1:0][EW-1:0] stream;
  logic [PW-1:0]          pos;
  logic [BW-1:0]          n;
  logic                   stop;

  always_comb begin
    stream = '0;
    for (int i = 0; i < DEPTH; i++) stream[i] = skid_ent[i];
    // append accepted arrivals behind the parked entries, gaps removed
    pos = PW'(skid_cnt);
    for (int j = 0; j < WIDTH; j++) begin
      if (accept && in_valid[j]) begin
        stream[pos] = in_ent[j];
        pos = pos + PW'(1);
      end
    end
    total = pos;

    n    = '0;
    stop = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!stop && (PW'(i) < total) && (BW'(i) < budget)) begin
        if (stream[i][EW-1]) begin
          if (i == 0 && drained) n = BW'(1);
          stop = 1'b1;
        end else begin
          n = n + BW'(1);
        end
      end else begin
        stop = 1'b1;
      end
    end

    for (int i = 0; i < WIDTH; i++) begin
      issue_mask[i] = BW'(i) < n;
      issue_data[i] = stream[i][DATA_W-1:0];
    end
    first_is_barrier = stream[0][EW-1];

    for (int k = 0; k < DEPTH; k++) left_ent[k] = stream[PW'(k) + PW'(n)];
    left_n       = total - PW'(n);
    head_barrier = (left_n != '0) && stream[PW'(n)][EW-1];
  end

endmodule

// File: rtl/rename_flow_ctl.sv
module rename_flow_ctl #(
  parameter  int WIDTH      = 4,
  parameter  int DATA_W     = 8,
  parameter  int CNT_W      = 6,
  parameter  int SKID_DEPTH = 2 * WIDTH,
  localparam int EW         = DATA_W + 1,
  localparam int CW         = $clog2(SKID_DEPTH + 1),
  localparam int PW         = $clog2(SKID_DEPTH + WIDTH + 1),
  localparam int BW         = $clog2(WIDTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      squash,
  input  logic [WIDTH-1:0]          in_valid,
  input  logic [WIDTH-1:0]          in_barrier,
  input  logic [WIDTH*DATA_W-1:0]   in_data,
  input  logic [CNT_W-1:0]          rob_free,
  input  logic [CNT_W-1:0]          iq_free,
  input  logic [CNT_W-1:0]          lsq_free,
  input  logic                      rob_empty,
  input  logic [CNT_W-1:0]          inflight,
  output logic [WIDTH-1:0]          out_valid,
  output logic [WIDTH*DATA_W-1:0]   out_data,
  output logic                      hold_decode,
  output logic [2:0]                stage_status
);
  import rn_pkg::*;

  logic [WIDTH-1:0][EW-1:0]      in_ent;
  logic [SKID_DEPTH-1:0][EW-1:0] skid_ent, left_ent;
  logic [CW-1:0]                 skid_cnt;
  logic [BW-1:0]                 budget;
  logic [WIDTH-1:0]              issue_mask;
  logic [WIDTH-1:0][DATA_W-1:0]  issue_data;
  logic                          first_is_barrier, head_barrier;
  logic [PW-1:0]                 left_n, total;

  rn_status_e               st_q, st_d;
  logic [WIDTH-1:0]         valid_q, valid_d;
  logic [WIDTH*DATA_W-1:0]  data_q, data_d;
  logic                     hold_q, hold_d;
  logic                     flushing, accept, drained, skid_clr, skid_wr, data_en;

  for (genvar j = 0; j < WIDTH; j++) begin : g_pack
    assign in_ent[j] = {in_barrier[j], in_data[j*DATA_W +: DATA_W]};
    assign data_d[j*DATA_W +: DATA_W] = issue_data[j];
  end

  assign flushing = (st_q == ST_SQ_START) || (st_q == ST_SQ_BUSY);
  assign accept   = !squash && !flushing;
  assign drained  = rob_empty && (inflight == '0);

  rn_budget #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_budget (
    .rob_free(rob_free), .iq_free(iq_free), .lsq_free(lsq_free), .budget(budget)
  );

  rn_select #(.WIDTH(WIDTH), .DEPTH(SKID_DEPTH), .DATA_W(DATA_W)) u_select (
    .skid_ent(skid_ent), .skid_cnt(skid_cnt), .in_valid(in_valid), .in_ent(in_ent),
    .accept(accept), .budget(budget), .drained(drained),
    .issue_mask(issue_mask), .issue_data(issue_data), .first_is_barrier(first_is_barrier),
    .left_ent(left_ent), .left_n(left_n), .total(total), .head_barrier(head_barrier)
  );

  rn_skid #(.DEPTH(SKID_DEPTH), .EW(EW)) u_skid (
    .clk(clk), .rst_n(rst_n), .clr(skid_clr), .wr_en(skid_wr),
    .wr_cnt(CW'(left_n)), .wr_ent(left_ent), .ent(skid_ent), .cnt(skid_cnt)
  );

  always_comb begin
    st_d     = st_q;
    valid_d  = '0;
    skid_clr = 1'b0;
    skid_wr  = 1'b0;
    if (squash) begin
      st_d     = ST_SQ_START;
      skid_clr = 1'b1;
    end else if (st_q == ST_SQ_START) begin
      st_d     = ST_SQ_BUSY;
      skid_clr = 1'b1;
    end else if (st_q == ST_SQ_BUSY) begin
      st_d     = ST_RUN;
      skid_clr = 1'b1;
    end else begin
      skid_wr = 1'b1;
      valid_d = issue_mask;
      if (left_n == '0)           st_d = (total == '0) ? ST_IDLE : ST_RUN;
      else if (head_barrier)      st_d = ST_SERIAL;
      else if (issue_mask == '0)  st_d = ST_BLOCK;
      else if (is_stall(st_q))    st_d = ST_UNBLOCK;
      else                        st_d = ST_BLOCK;
    end
    hold_d  = is_stall(st_d) || (st_d == ST_SQ_START);
    data_en = |valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      valid_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      hold_q  <= hold_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  assign out_valid    = valid_q;
  assign out_data     = data_q;
  assign hold_decode  = hold_q;
  assign stage_status = st_q;

  // R10: parked entries never outgrow the skid storage
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (left_n <= PW'(SKID_DEPTH)));

  // R11: issued slots form a run from slot 0
  p_contig_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_q & (valid_q + WIDTH'(1))) == '0));

  // R3: never more issued than any credit count allowed
  p_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(out_valid) <= $past(rob_free)) &&
             ($countones(out_valid) <= $past(iq_free)) &&
             ($countones(out_valid) <= $past(lsq_free)));

  // R7: a barrier only leaves once the pipe behind it is drained
  p_barrier_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && issue_mask[0] && first_is_barrier) |-> drained);

  // R8: squash sequence and silence
  p_squash_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (stage_status == 3'd2) && (out_valid == '0));
  p_squash_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_status == 3'd3 && !squash) |=> (stage_status == 3'd0));

  // R6: running status implies nothing is parked
  p_run_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (skid_cnt == '0));

endmodule

// File: tb/rename_flow_ctl_test.sv
`timescale 1ns/1ps
module rename_flow_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        squash;
  logic [3:0]  in_valid, in_barrier;
  logic [31:0] in_data;
  logic [5:0]  rob_free, iq_free, lsq_free, inflight;
  logic        rob_empty;
  logic [3:0]  out_valid;
  logic [31:0] out_data;
  logic        hold_decode;
  logic [2:0]  stage_status;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rename_flow_ctl uut (
    .clk(clk), .rst_n(rst_n), .squash(squash), .in_valid(in_valid),
    .in_barrier(in_barrier), .in_data(in_data), .rob_free(rob_free),
    .iq_free(iq_free), .lsq_free(lsq_free), .rob_empty(rob_empty),
    .inflight(inflight), .out_valid(out_valid), .out_data(out_data),
    .hold_decode(hold_decode), .stage_status(stage_status)
  );

  typedef struct packed {
    logic [3:0]  v;
    logic [3:0]  b;
    logic [31:0] d;
    logic [5:0]  rob;
    logic [5:0]  iq;
    logic [5:0]  lsq;
    logic        emp;
    logic [5:0]  inf;
    logic [3:0]  ev;
    logic [31:0] ed;
    logic [2:0]  es;
    logic        eh;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [12] = '{
    // R2: full group straight through
    '{4'hF, 4'h0, 32'h13121110, 6'd20, 6'd20, 6'd20, 1'b0, 6'd3, 4'hF, 32'h13121110, 3'd0, 1'b0, 4'd2},
    // R2, R11: sparse group compacted to slots 0 and 1
    '{4'hA, 4'h0, 32'h23EE21EE, 6'd20, 6'd20, 6'd20, 1'b0, 6'd3, 4'h3, 32'h00002321, 3'd0, 1'b0, 4'd2},
    // R9: nothing arrives, status idle
    '{4'h0, 4'h0, 32'h0,        6'd20, 6'd20, 6'd20, 1'b0, 6'd0, 4'h0, 32'h0,        3'd1, 1'b0, 4'd9},
    // R3, R4: reorder-buffer credit 2, two parked, blocked
    '{4'hF, 4'h0, 32'h33323130, 6'd2,  6'd20, 6'd20, 1'b0, 6'd0, 4'h3, 32'h00003130, 3'd4, 1'b1, 4'd4},
    // R5, R10: stray group, parked first, issue-queue credit 3
    '{4'hF, 4'h0, 32'h43424140, 6'd20, 6'd3,  6'd20, 1'b0, 6'd0, 4'h7, 32'h00403332, 3'd5, 1'b1, 4'd5},
    // R3: load/store credit zero, nothing issues
    '{4'h0, 4'h0, 32'h0,        6'd20, 6'd20, 6'd0,  1'b0, 6'd0, 4'h0, 32'h0,        3'd4, 1'b1, 4'd3},
    // R6: partial drain, unblocking
    '{4'h0, 4'h0, 32'h0,        6'd20, 6'd20, 6'd2,  1'b0, 6'd0, 4'h3, 32'h00004241, 3'd5, 1'b1, 4'd6},
    // R6: last parked leaves, running, hold released
    '{4'h0, 4'h0, 32'h0,        6'd20, 6'd20, 6'd20, 1'b0, 6'd0, 4'h1, 32'h00000043, 3'd0, 1'b0, 4'd6},
    // R7: barrier in slot 2, older two leave
    '{4'hF, 4'h4, 32'h53525150, 6'd20, 6'd20, 6'd20, 1'b0, 6'd2, 4'h3, 32'h00005150, 3'd6, 1'b1, 4'd7},
    // R7: reorder buffer empty but one in flight, barrier waits
    '{4'h0, 4'h0, 32'h0,        6'd20, 6'd20, 6'd20, 1'b1, 6'd1, 4'h0, 32'h0,        3'd6, 1'b1, 4'd7},
    // R7: drained, barrier leaves alone
    '{4'h0, 4'h0, 32'h0,        6'd20, 6'd20, 6'd20, 1'b1, 6'd0, 4'h1, 32'h00000052, 3'd5, 1'b1, 4'd7},
    // R6: trailing instruction, running again
    '{4'h0, 4'h0, 32'h0,        6'd20, 6'd20, 6'd20, 1'b1, 6'd0, 4'h1, 32'h00000053, 3'd0, 1'b0, 4'd6}
  };

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(string req, logic [3:0] ev, logic [31:0] ed, logic [2:0] es, logic eh);
    logic [31:0] got_m, exp_m;
    got_m = '0;
    exp_m = '0;
    for (int j = 0; j < 4; j++) begin
      if (ev[j]) begin
        got_m[j*8 +: 8] = out_data[j*8 +: 8];
        exp_m[j*8 +: 8] = ed[j*8 +: 8];
      end
    end
    checks++;
    if (out_valid !== ev || got_m !== exp_m || stage_status !== es || hold_decode !== eh) begin
      fails++;
      $display("FAIL %s: valid=%b data=%h status=%0d hold=%b, expected valid=%b data=%h status=%0d hold=%b",
               req, out_valid, got_m, stage_status, hold_decode, ev, exp_m, es, eh);
    end
  endtask

  task automatic apply(logic [3:0] v, logic [3:0] b, logic [31:0] d, logic [5:0] rob,
                       logic [5:0] iq, logic [5:0] lsq, logic emp, logic [5:0] inf, logic sq);
    in_valid = v; in_barrier = b; in_data = d;
    rob_free = rob; iq_free = iq; lsq_free = lsq;
    rob_empty = emp; inflight = inf; squash = sq;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run still active after 20000 cycles, expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; squash = 1'b0; in_valid = '0; in_barrier = '0; in_data = '0;
    rob_free = 6'd20; iq_free = 6'd20; lsq_free = 6'd20; rob_empty = 1'b0; inflight = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", 4'h0, 32'h0, 3'd1, 1'b0);

    for (int i = 0; i < 12; i++) begin
      apply(TBL[i].v, TBL[i].b, TBL[i].d, TBL[i].rob, TBL[i].iq, TBL[i].lsq,
            TBL[i].emp, TBL[i].inf, 1'b0);
      chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].ev, TBL[i].ed, TBL[i].es, TBL[i].eh);
    end

    // R4: no credit at all, whole group parked
    apply(4'hF, 4'h0, 32'h63626160, 6'd0, 6'd20, 6'd20, 1'b0, 6'd0, 1'b0);
    chk("R4", 4'h0, 32'h0, 3'd4, 1'b1);
    // R8: squash with a stray group present
    apply(4'hF, 4'h0, 32'h63626160, 6'd20, 6'd20, 6'd20, 1'b0, 6'd0, 1'b1);
    chk("R8 start", 4'h0, 32'h0, 3'd2, 1'b1);
    apply(4'hF, 4'h0, 32'h67666564, 6'd20, 6'd20, 6'd20, 1'b0, 6'd0, 1'b0);
    chk("R8 busy", 4'h0, 32'h0, 3'd3, 1'b0);
    apply(4'hF, 4'h0, 32'h73727170, 6'd20, 6'd20, 6'd20, 1'b0, 6'd0, 1'b0);
    chk("R8 exit", 4'h0, 32'h0, 3'd0, 1'b0);
    apply(4'h0, 4'h0, 32'h0, 6'd20, 6'd20, 6'd20, 1'b0, 6'd0, 1'b0);
    chk("R8 cleared", 4'h0, 32'h0, 3'd1, 1'b0);

    // R1: reset in the middle of a stall
    apply(4'hF, 4'h0, 32'h83828180, 6'd1, 6'd20, 6'd20, 1'b0, 6'd0, 1'b0);
    chk("R3 pre-reset", 4'h1, 32'h00000080, 3'd4, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 async", 4'h0, 32'h0, 3'd1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(4'h0, 4'h0, 32'h0, 6'd20, 6'd20, 6'd20, 1'b0, 6'd0, 1'b0);
    chk("R1 skid empty", 4'h0, 32'h0, 3'd1, 1'b0);

    report();
    $finish;
  end

endmodule